// File: doc/BRIEF.md
# Bit Field Insert and Extract Unit

This unit executes the two bit-string instructions of a 64-bit integer pipeline, each in a 32-bit (word) and a 64-bit (doubleword) form. The instruction word carries the upper and lower bound of a bit field as immediates. Insert overwrites that field of the current destination value with the low bits of the source operand and keeps every other destination bit, so it is a read-modify-write of the destination. Extract cuts the field out of the source operand and returns it shifted down to bit 0, with zeros above it.

The register file lies outside the unit. Each cycle the pipeline presents a qualified instruction word together with the source value and the current destination value. One clock later the unit returns the destination index, a write strobe and the result. Bounds where the lower bound lies above the upper bound are flagged as illegal and are never written. The word forms produce a 32-bit result that is sign-extended to 64 bits.

Top module: `bit_field_unit`

## Requirements
- R1: Word forms are recognised when instruction bits 31:21 equal 00000000011. Bit 15 chooses insert (0) or extract (1), the upper bound is bits 20:16, the lower bound is bits 14:10, and the destination index is bits 4:0 in every form.
- R2: Doubleword insert is recognised when bits 31:22 equal 0000000010, and doubleword extract when they equal 0000000011. The upper bound is bits 21:16 and the lower bound is bits 15:10.
- R3: A cycle with `op_valid` low, or with an instruction word that matches none of the four forms, gives `wr_en` = 0 and `bad_field` = 0 in the next cycle.
- R4: When the lower bound is greater than the upper bound, the next cycle has `bad_field` = 1 and `wr_en` = 0, whatever the destination index.
- R5: Doubleword insert returns the destination value with bits upper..lower replaced by source bits (upper-lower)..0. All other bits keep their destination value.
- R6: Word insert performs the same merge on the low 32 destination bits. The 32-bit result is sign-extended from bit 31.
- R7: Doubleword extract returns source bits upper..lower at bit 0, with every bit above the field zero.
- R8: Word extract returns source bits upper..lower at bit 0 as a 32-bit value and sign-extends it from bit 31. With upper = 31 and lower = 0 this is the low source word, sign-extended.
- R9: A legal instruction whose destination index is 0 produces `wr_en` = 0 and `bad_field` = 0.
- R10: Results appear exactly one clock after the instruction is presented. A synchronous active-high reset clears `wr_en`, `bad_field`, `wr_idx` and `wr_data` in the next cycle, even when an instruction is presented at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Source operand value |
| dst_old | input | 64 | Current destination register value |
| wr_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write the result to `wr_idx` |
| wr_data | output | 64 | Result value |
| bad_field | output | 1 | Instruction rejected: lower bound above upper bound |

## Verification
Two conditions can meet in one instruction: reversed bounds and a zero destination index. The bench sends reversed-bound instructions addressed to register 0 and to non-zero registers, in both widths. In each case it expects `bad_field` high and `wr_en` low. A legal instruction to register 0 must raise neither flag. Insert and extract are also issued back to back, so that each result registered in one cycle is checked against its own instruction and not the one that follows.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  // Operation selected by the decoder
  typedef enum logic [1:0] {
    BF_OP_NONE = 2'd0,
    BF_OP_INS  = 2'd1,
    BF_OP_EXT  = 2'd2
  } bf_op_e;

  // Opcode keys: word forms use bits 31:21, doubleword forms use bits 31:22
  localparam logic [10:0] BF_KEY_WORD   = 11'b00000000011;
  localparam logic [9:0]  BF_KEY_DW_INS = 10'b0000000010;
  localparam logic [9:0]  BF_KEY_DW_EXT = 10'b0000000011;

endpackage

// File: rtl/bfu_decode.sv
module bfu_decode
  import bfu_pkg::*;
#(
  parameter int unsigned BW = 6,
  parameter int unsigned RW = 5
) (
  input  logic [31:0]   instr,
  output bf_op_e        op,
  output logic          word,
  output logic [BW-1:0] msb,
  output logic [BW-1:0] lsb,
  output logic [RW-1:0] dst,
  output logic          bounds_bad
);

  localparam int unsigned MSB_POS = 16;
  localparam int unsigned LSB_POS = 10;
  localparam int unsigned SEL_POS = 15;

  logic is_word, is_dw_ins, is_dw_ext;

  assign is_word   = (instr[31:21] == BF_KEY_WORD);
  assign is_dw_ins = (instr[31:22] == BF_KEY_DW_INS);
  assign is_dw_ext = (instr[31:22] == BF_KEY_DW_EXT);

  always_comb begin
    op   = BF_OP_NONE;
    word = 1'b0;
    msb  = instr[MSB_POS +: BW];
    lsb  = instr[LSB_POS +: BW];
    if (is_word) begin
      word = 1'b1;
      op   = instr[SEL_POS] ? BF_OP_EXT : BF_OP_INS;
      msb  = {1'b0, instr[MSB_POS +: BW-1]};
      lsb  = {1'b0, instr[LSB_POS +: BW-1]};
    end else if (is_dw_ins) begin
      op = BF_OP_INS;
    end else if (is_dw_ext) begin
      op = BF_OP_EXT;
    end
  end

  assign dst        = instr[RW-1:0];
  assign bounds_bad = (lsb > msb);

endmodule

// File: rtl/bfu_mask.sv
module bfu_mask #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned BW   = 6
) (
  input  logic [BW-1:0]   msb,
  input  logic [BW-1:0]   lsb,
  output logic [XLEN-1:0] mask
);

  // One comparator pair per bit position
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    localparam logic [BW-1:0] POS = BW'(i);
    assign mask[i] = (POS >= lsb) && (POS <= msb);
  end

endmodule

// File: rtl/bfu_engine.sv
module bfu_engine
  import bfu_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned BW   = 6
) (
  input  bf_op_e          op,
  input  logic            word,
  input  logic [BW-1:0]   msb,
  input  logic [BW-1:0]   lsb,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] dst_old,
  output logic [XLEN-1:0] result
);

  localparam int unsigned HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] widen_half(input logic [XLEN-1:0] v);
    return {{HALF{v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] deposit(input logic [XLEN-1:0] base,
                                              input logic [XLEN-1:0] val,
                                              input logic [XLEN-1:0] m,
                                              input logic [BW-1:0]   at);
    return (base & ~m) | ((val << at) & m);
  endfunction

  function automatic logic [XLEN-1:0] pull(input logic [XLEN-1:0] val,
                                           input logic [XLEN-1:0] m,
                                           input logic [BW-1:0]   at);
    return (val & m) >> at;
  endfunction

  logic [XLEN-1:0] field_mask;
  logic [XLEN-1:0] merged, picked, raw;

  bfu_mask #(.XLEN(XLEN), .BW(BW)) u_mask (
    .msb  (msb),
    .lsb  (lsb),
    .mask (field_mask)
  );

  assign merged = deposit(dst_old, src, field_mask, lsb);
  assign picked = pull(src, field_mask, lsb);
  assign raw    = (op == BF_OP_INS) ? merged : picked;
  assign result = word ? widen_half(raw) : raw;

endmodule

// File: rtl/bit_field_unit.sv
module bit_field_unit
  import bfu_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned RW   = 5,
  localparam int unsigned BW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] dst_old,
  output logic [RW-1:0]   wr_idx,
  output logic            wr_en,
  output logic [XLEN-1:0] wr_data,
  output logic            bad_field
);

  bf_op_e          dec_op;
  logic            dec_word;
  logic [BW-1:0]   dec_msb, dec_lsb;
  logic [RW-1:0]   dec_dst;
  logic            dec_bad;
  logic [XLEN-1:0] eng_result;

  // Named events for the checker
  logic op_seen, dst_nonzero, commit, reject;

  bfu_decode #(.BW(BW), .RW(RW)) u_dec (
    .instr      (instr),
    .op         (dec_op),
    .word       (dec_word),
    .msb        (dec_msb),
    .lsb        (dec_lsb),
    .dst        (dec_dst),
    .bounds_bad (dec_bad)
  );

  bfu_engine #(.XLEN(XLEN), .BW(BW)) u_eng (
    .op      (dec_op),
    .word    (dec_word),
    .msb     (dec_msb),
    .lsb     (dec_lsb),
    .src     (src_val),
    .dst_old (dst_old),
    .result  (eng_result)
  );

  assign op_seen     = op_valid && (dec_op != BF_OP_NONE);
  assign dst_nonzero = (dec_dst != '0);
  assign commit      = op_seen && !dec_bad && dst_nonzero;
  assign reject      = op_seen && dec_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      bad_field <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en     <= commit;
      bad_field <= reject;
      wr_idx    <= dec_dst;
      wr_data   <= eng_result;
    end
  end

endmodule

// File: rtl/bfu_chk.sv
module bfu_chk
  import bfu_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned RW   = 5,
  parameter int unsigned BW   = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input bf_op_e          dec_op,
  input logic            dec_word,
  input logic            dec_bad,
  input logic [BW-1:0]   dec_msb,
  input logic [RW-1:0]   wr_idx,
  input logic            wr_en,
  input logic [XLEN-1:0] wr_data,
  input logic            bad_field
);

  localparam int unsigned HALF = XLEN / 2;

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && dec_op != BF_OP_NONE) |=> (!wr_en && !bad_field));

  // R4
  bad_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && dec_op != BF_OP_NONE && dec_bad) |=> (bad_field && !wr_en));

  // R9
  zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx != '0));

  // R7
  ext_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && dec_op == BF_OP_EXT && !dec_word && !dec_bad)
    |=> ((wr_data >> ({1'b0, $past(dec_msb)} + 1'b1)) == '0));

  // R6
  word_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && dec_op != BF_OP_NONE && dec_word && !dec_bad)
    |=> (($countones(wr_data[XLEN-1:HALF-1]) == 0) ||
         ($countones(wr_data[XLEN-1:HALF-1]) == HALF + 1)));

endmodule

bind bit_field_unit bfu_chk #(.XLEN(XLEN), .RW(RW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .dec_op    (dec_op),
  .dec_word  (dec_word),
  .dec_bad   (dec_bad),
  .dec_msb   (dec_msb),
  .wr_idx    (wr_idx),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .bad_field (bad_field)
);

// File: tb/bit_field_unit_tb.sv
module bit_field_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_val = '0;
  logic [63:0] dst_old = '0;
  logic [4:0]  wr_idx;
  logic        wr_en;
  logic [63:0] wr_data;
  logic        bad_field;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  bit_field_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .instr(instr),
    .src_val(src_val), .dst_old(dst_old), .wr_idx(wr_idx),
    .wr_en(wr_en), .wr_data(wr_data), .bad_field(bad_field)
  );

  // Encoders (R1, R2 field positions)
  function automatic logic [31:0] enc_w(bit ins, int msb, int lsb, logic [4:0] rd);
    logic [4:0] m = msb[4:0];
    logic [4:0] l = lsb[4:0];
    return {11'b00000000011, m, ~ins, l, 5'd9, rd};
  endfunction

  function automatic logic [31:0] enc_d(bit ins, int msb, int lsb, logic [4:0] rd);
    logic [5:0] m = msb[5:0];
    logic [5:0] l = lsb[5:0];
    return {(ins ? 10'b0000000010 : 10'b0000000011), m, l, 5'd9, rd};
  endfunction

  // Bit-by-bit reference
  function automatic logic [63:0] model(bit ins, bit word, int msb, int lsb,
                                       logic [63:0] s, logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      if (ins) r[i] = (i >= lsb && i <= msb) ? s[i - lsb] : d[i];
      else     r[i] = (i <= msb - lsb) ? s[i + lsb] : 1'b0;
    end
    if (word) for (int i = 32; i < 64; i++) r[i] = r[31];
    return r;
  endfunction

  // Drive one instruction, check the registered result one clock later
  task automatic run_op(string tag, logic [31:0] iw, logic [63:0] s, logic [63:0] d,
                        bit exp_en, bit exp_bad, logic [63:0] exp_data);
    bit ok;
    @(negedge clk);
    op_valid = 1'b1; instr = iw; src_val = s; dst_old = d;
    @(negedge clk);
    op_valid = 1'b0;
    ok = (wr_en == exp_en) && (bad_field == exp_bad);
    if (exp_en) ok = ok && (wr_data == exp_data) && (wr_idx == iw[4:0]);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: en=%0b bad=%0b idx=%0d data=%h expected en=%0b bad=%0b idx=%0d data=%h",
               tag, wr_en, bad_field, wr_idx, wr_data, exp_en, exp_bad, iw[4:0], exp_data);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    n_checks++;
    if (wr_en !== 1'b0 || bad_field !== 1'b0 || wr_data !== '0 || wr_idx !== '0) begin
      n_fails++;
      $display("FAIL R10 reset: en=%b bad=%b idx=%h data=%h expected all zero",
               wr_en, bad_field, wr_idx, wr_data);
    end
  endtask

  task automatic t_word_sweep();
    for (int m = 0; m < 32; m++)
      for (int l = 0; l <= m; l++) begin
        logic [63:0] s = {$urandom, $urandom};
        logic [63:0] d = {$urandom, $urandom};
        run_op("R1 R6 word insert", enc_w(1, m, l, 5'd3), s, d, 1, 0, model(1, 1, m, l, s, d));
        run_op("R1 R8 word extract", enc_w(0, m, l, 5'd4), s, d, 1, 0, model(0, 1, m, l, s, d));
      end
  endtask

  task automatic t_dword_random();
    for (int k = 0; k < 400; k++) begin
      int a = $urandom_range(63);
      int b = $urandom_range(63);
      int m = (a > b) ? a : b;
      int l = (a > b) ? b : a;
      logic [63:0] s = {$urandom, $urandom};
      logic [63:0] d = {$urandom, $urandom};
      run_op("R2 R5 dword insert", enc_d(1, m, l, 5'd17), s, d, 1, 0, model(1, 0, m, l, s, d));
      run_op("R2 R7 dword extract", enc_d(0, m, l, 5'd18), s, d, 1, 0, model(0, 0, m, l, s, d));
    end
  endtask

  task automatic t_edges();
    logic [63:0] s = 64'h8123_4567_F9AB_CDEF;
    logic [63:0] d = 64'h0F0F_0F0F_7070_7070;
    run_op("R5 full width insert", enc_d(1, 63, 0, 5'd1), s, d, 1, 0, s);
    run_op("R7 full width extract", enc_d(0, 63, 0, 5'd1), s, d, 1, 0, s);
    run_op("R7 top bit extract", enc_d(0, 63, 63, 5'd2), s, d, 1, 0, 64'd1);
    run_op("R5 single bit insert", enc_d(1, 0, 0, 5'd2), 64'h0, 64'hFF, 1, 0, 64'hFE);
    run_op("R8 low word sext", enc_w(0, 31, 0, 5'd5), s, d, 1, 0, 64'hFFFF_FFFF_F9AB_CDEF);
    run_op("R8 msb31 lsb4 zero fill", enc_w(0, 31, 4, 5'd5), s, d, 1, 0, 64'h0000_0000_0F9A_BCDE);
    run_op("R6 word insert sets bit31", enc_w(1, 31, 31, 5'd6), 64'h1, 64'h0, 1, 0,
           64'hFFFF_FFFF_8000_0000);
    run_op("R6 word insert clears bit31", enc_w(1, 31, 28, 5'd6), 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
           1, 0, 64'h0000_0000_0FFF_FFFF);
  endtask

  task automatic t_illegal_and_zero();
    logic [63:0] s = 64'h1111_2222_3333_4444;
    run_op("R4 word reversed", enc_w(1, 3, 4, 5'd7), s, s, 0, 1, '0);
    run_op("R4 word extract reversed", enc_w(0, 0, 31, 5'd7), s, s, 0, 1, '0);
    run_op("R4 dword reversed", enc_d(0, 10, 11, 5'd8), s, s, 0, 1, '0);
    run_op("R4 R9 reversed to r0", enc_d(1, 5, 40, 5'd0), s, s, 0, 1, '0);
    run_op("R4 R9 word reversed to r0", enc_w(0, 1, 2, 5'd0), s, s, 0, 1, '0);
    run_op("R9 legal to r0", enc_d(1, 20, 3, 5'd0), s, s, 0, 0, '0);
    run_op("R9 word legal to r0", enc_w(0, 15, 0, 5'd0), s, s, 0, 0, '0);
  endtask

  task automatic t_unrecognised();
    run_op("R3 other opcode", 32'h0040_1C83, 64'h5, 64'h6, 0, 0, '0);
    run_op("R3 near miss opcode", 32'h0100_0083, 64'h5, 64'h6, 0, 0, '0);
    // Valid low with a legal word: must not write
    @(negedge clk);
    op_valid = 1'b0; instr = enc_w(1, 7, 0, 5'd3);
    @(negedge clk);
    n_checks++;
    if (wr_en !== 1'b0 || bad_field !== 1'b0) begin
      n_fails++;
      $display("FAIL R3 valid low: en=%b bad=%b expected 0 0", wr_en, bad_field);
    end
  endtask

  task automatic t_back_to_back();
    logic [63:0] s = 64'hDEAD_BEEF_CAFE_F00D;
    logic [63:0] d = 64'h0123_4567_89AB_CDEF;
    logic [63:0] e1 = model(1, 0, 23, 8, s, d);
    logic [63:0] e2 = model(0, 1, 19, 12, s, d);
    @(negedge clk);
    op_valid = 1'b1; instr = enc_d(1, 23, 8, 5'd10); src_val = s; dst_old = d;
    @(negedge clk);
    instr = enc_w(0, 19, 12, 5'd11);
    n_checks++;
    if (!(wr_en && wr_idx == 5'd10 && wr_data == e1)) begin
      n_fails++;
      $display("FAIL R10 first of pair: idx=%0d data=%h expected idx=10 data=%h", wr_idx, wr_data, e1);
    end
    @(negedge clk);
    op_valid = 1'b0;
    n_checks++;
    if (!(wr_en && wr_idx == 5'd11 && wr_data == e2)) begin
      n_fails++;
      $display("FAIL R10 second of pair: idx=%0d data=%h expected idx=11 data=%h", wr_idx, wr_data, e2);
    end
  endtask

  task automatic t_reset_mid_run();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b1; instr = enc_d(1, 63, 0, 5'd12); src_val = '1;
    @(negedge clk);
    rst = 1'b0; op_valid = 1'b0;
    n_checks++;
    if (wr_en !== 1'b0 || bad_field !== 1'b0 || wr_data !== '0 || wr_idx !== '0) begin
      n_fails++;
      $display("FAIL R10 reset over op: en=%b idx=%h data=%h expected all zero", wr_en, wr_idx, wr_data);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_edges();
    t_illegal_and_zero();
    t_unrecognised();
    t_back_to_back();
    t_word_sweep();
    t_dword_random();
    t_reset_mid_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule